// File: doc/BRIEF.md
# Transmit DMA Channel Status and Error Register

This block gathers the state of up to eight transmit DMA channels into one read-only status word. It also records protocol faults in a second word of sticky error flags. Each channel supplies two levels: whether its buffers are empty and whether it has no outstanding requests. The block ANDs the two levels and presents the result as a per-channel idle vector.

The block detects two faults per channel:
- a new DMA command arrives while the channel's command buffer still holds the previous one;
- the transmit FIFO reports full while the channel's credit counter is not zero.

Two global pulses, an internal-memory address fault and a host dword-count shortfall, are also recorded. Every error flag stays set until software writes 1 to it. An interrupt line is high while any flag is set.

Access goes through a one-bit register select. Writes take effect at the clock edge. Reads are combinational from the selected word.

Top module: `tx_dma_stat_regs`

## Requirements
- R1: With `reg_sel`=0 the read word holds buffers-empty for channels 7..0 in bits 31:24 and no-pending for channels 7..0 in bits 23:16, and reads 0 in bits 15:0.
- R2: `chan_idle[i]` is 1 exactly when both the buffers-empty and the no-pending levels of channel i are 1.
- R3: A cycle with `addr_err` high sets error bit 31 at the following edge.
- R4: A cycle with `dword_short` high sets error bit 30 at the following edge.
- R5: A cycle with `cmd_valid[i]` and `cmd_buf_full[i]` both high sets error bit 9+i. A command while the buffer is not full sets nothing.
- R6: A cycle with `fifo_full[i]` and `credit_nz[i]` both high sets error bit i. A full indication with zero credit sets nothing.
- R7: An error bit stays set until a write with `reg_sel`=1 carries 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R8: When an error event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R9: Writes with `reg_sel`=0 change neither the status word nor any error bit.
- R10: `irq` is high exactly while at least one error bit is set.
- R11: Reset clears every error bit and drops `irq`.
- R12: Error bits 29:17 and bit 8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_bufs_empty | input | NCH | Per-channel buffers-empty level |
| chan_no_pend | input | NCH | Per-channel no-outstanding-request level |
| cmd_valid | input | NCH | Per-channel new-command strobe |
| cmd_buf_full | input | NCH | Per-channel command buffer occupied |
| fifo_full | input | NCH | Per-channel transmit FIFO full indication |
| credit_nz | input | NCH | Per-channel credit counter is nonzero |
| addr_err | input | 1 | Internal-memory address fault pulse |
| dword_short | input | 1 | Host dword-count shortfall pulse |
| reg_sel | input | 1 | 0 selects status word, 1 selects error word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data (1 bits clear error flags) |
| rd_data | output | 32 | Selected register contents |
| chan_idle | output | NCH | Per-channel idle (empty and no pending) |
| irq | output | 1 | High while any error flag is set |

## Verification
The assertions treat every event input as a one-cycle sample taken at the clock edge, with no hand-off between inputs. A strobe held for several cycles therefore counts as several events, and the assertions expect the flag to be set after each of them. The assertions also take the write data as already masked: they reason only about bits that a write may clear. The stimulus changes inputs only at the falling edge, drops them after one rising edge, and places coincident set and clear traffic in the same cycle on purpose, so that the precedence rule is reached.

// File: rtl/txds_pkg.sv
package txds_pkg;
  localparam int REG_W      = 32;
  localparam int MAX_CH     = 8;
  localparam int EMPTY_LSB  = 24;
  localparam int NOPEND_LSB = 16;
  localparam int OVR_LSB    = 9;
  localparam int CRED_LSB   = 0;
  localparam int ADDR_BIT   = 31;
  localparam int SHORT_BIT  = 30;

  // Build the read-only status word from padded per-channel levels.
  function automatic logic [REG_W-1:0] pack_status(input logic [MAX_CH-1:0] empty_v,
                                                   input logic [MAX_CH-1:0] nopend_v);
    logic [REG_W-1:0] w;
    w = '0;
    w[EMPTY_LSB  +: MAX_CH] = empty_v;
    w[NOPEND_LSB +: MAX_CH] = nopend_v;
    return w;
  endfunction

  // Bits of the error word that exist for a given channel count.
  function automatic logic [REG_W-1:0] err_mask(input int nch);
    logic [REG_W-1:0] m;
    m = '0;
    m[ADDR_BIT]  = 1'b1;
    m[SHORT_BIT] = 1'b1;
    for (int i = 0; i < MAX_CH; i++) begin
      if (i < nch) begin
        m[OVR_LSB + i]  = 1'b1;
        m[CRED_LSB + i] = 1'b1;
      end
    end
    return m;
  endfunction

  // Sticky update: clear first, then set, so a coincident event wins.
  function automatic logic [REG_W-1:0] next_sticky(input logic [REG_W-1:0] q,
                                                   input logic [REG_W-1:0] set_v,
                                                   input logic [REG_W-1:0] clr_v,
                                                   input logic [REG_W-1:0] mask);
    return ((q & ~clr_v) | set_v) & mask;
  endfunction
endpackage

// File: rtl/txds_evt_detect.sv
module txds_evt_detect #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0]             cmd_valid,
  input  logic [NCH-1:0]             cmd_buf_full,
  input  logic [NCH-1:0]             fifo_full,
  input  logic [NCH-1:0]             credit_nz,
  input  logic                       addr_err,
  input  logic                       dword_short,
  output logic [txds_pkg::REG_W-1:0] set_vec
);
  import txds_pkg::*;

  logic [NCH-1:0] ovr_hit;
  logic [NCH-1:0] cred_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign ovr_hit[i]  = cmd_valid[i] & cmd_buf_full[i];
    assign cred_hit[i] = fifo_full[i] & credit_nz[i];
  end

  always_comb begin
    set_vec = '0;
    set_vec[OVR_LSB  +: NCH] = ovr_hit;
    set_vec[CRED_LSB +: NCH] = cred_hit;
    set_vec[ADDR_BIT]        = addr_err;
    set_vec[SHORT_BIT]       = dword_short;
  end
endmodule

// File: rtl/txds_w1c_bank.sv
module txds_w1c_bank #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= txds_pkg::next_sticky(q, set_vec, clr_vec, MASK);
  end
endmodule

// File: rtl/tx_dma_stat_regs.sv
module tx_dma_stat_regs #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_bufs_empty,
  input  logic [NCH-1:0] chan_no_pend,
  input  logic [NCH-1:0] cmd_valid,
  input  logic [NCH-1:0] cmd_buf_full,
  input  logic [NCH-1:0] fifo_full,
  input  logic [NCH-1:0] credit_nz,
  input  logic           addr_err,
  input  logic           dword_short,
  input  logic           reg_sel,
  input  logic           wr_en,
  input  logic [31:0]    wr_data,
  output logic [31:0]    rd_data,
  output logic [NCH-1:0] chan_idle,
  output logic           irq
);
  import txds_pkg::*;

  localparam logic [REG_W-1:0] ERR_MASK = err_mask(NCH);

  logic [REG_W-1:0]  set_vec;
  logic [REG_W-1:0]  clr_vec;
  logic [REG_W-1:0]  err_q;
  logic [REG_W-1:0]  status_w;
  logic [MAX_CH-1:0] empty_pad;
  logic [MAX_CH-1:0] nopend_pad;

  txds_evt_detect #(.NCH(NCH)) u_detect (
    .cmd_valid    (cmd_valid),
    .cmd_buf_full (cmd_buf_full),
    .fifo_full    (fifo_full),
    .credit_nz    (credit_nz),
    .addr_err     (addr_err),
    .dword_short  (dword_short),
    .set_vec      (set_vec)
  );

  assign clr_vec = (wr_en && reg_sel) ? (wr_data & ERR_MASK) : '0;

  txds_w1c_bank #(.W(REG_W), .MASK(ERR_MASK)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (err_q)
  );

  always_comb begin
    empty_pad  = '0;
    nopend_pad = '0;
    empty_pad[NCH-1:0]  = chan_bufs_empty;
    nopend_pad[NCH-1:0] = chan_no_pend;
    status_w = pack_status(empty_pad, nopend_pad);
  end

  assign chan_idle = chan_bufs_empty & chan_no_pend;
  assign rd_data   = reg_sel ? err_q : status_w;
  assign irq       = |err_q;
endmodule

// File: rtl/tx_dma_stat_chk.sv
module tx_dma_stat_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] cmd_valid,
  input logic [NCH-1:0] cmd_buf_full,
  input logic [NCH-1:0] fifo_full,
  input logic [NCH-1:0] credit_nz,
  input logic           addr_err,
  input logic           dword_short,
  input logic           irq,
  input logic [31:0]    err_q,
  input logic [31:0]    set_vec,
  input logic [31:0]    clr_vec
);
  assert_addr_latch_R3: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> err_q[31]);

  assert_short_latch_R4: assert property (@(posedge clk) disable iff (rst)
    dword_short |=> err_q[30]);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_ovr_latch_R5: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid[i] && cmd_buf_full[i]) |=> err_q[9 + i]);
    assert_cred_latch_R6: assert property (@(posedge clk) disable iff (rst)
      (fifo_full[i] && credit_nz[i]) |=> err_q[i]);
  end

  // R7: a set bit only drops when a clear addressed it in the prior cycle
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(err_q) & ~$past(clr_vec) & ~err_q) == 32'h0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & clr_vec) != 32'h0) |=>
      ((err_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(irq)) |-> ($past(set_vec) != 32'h0));

  assert_reset_clear_R11: assert property (@(posedge clk)
    $past(rst) |-> (err_q == 32'h0 && !irq));
endmodule

bind tx_dma_stat_regs tx_dma_stat_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_tx_dma_stat_regs.sv
module tb_tx_dma_stat_regs;
  localparam int CLK_P = 10;
  localparam int NCH   = 8;
  localparam int NVEC  = 6;

  // {cmd_valid, cmd_buf_full, fifo_full, credit_nz, addr, short, wr_en, wr_data, expected error word}
  localparam logic [32+2+1+32+32-1:0] VEC [NVEC] = '{
    {8'h05, 8'h04, 8'h30, 8'h10, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0810},
    {8'hFF, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 32'h8000_0810},
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 32'h0000_0800, 32'hC000_0010},
    {8'h80, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 32'h0001_0010, 32'hC001_0000},
    {8'h00, 8'h00, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001},
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] chan_bufs_empty = '0, chan_no_pend = '0;
  logic [NCH-1:0] cmd_valid = '0, cmd_buf_full = '0, fifo_full = '0, credit_nz = '0;
  logic           addr_err = 1'b0, dword_short = 1'b0;
  logic           reg_sel = 1'b0, wr_en = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [31:0]    rd_data;
  logic [NCH-1:0] chan_idle;
  logic           irq;

  int nchk = 0;
  int nerr = 0;

  tx_dma_stat_regs #(.NCH(NCH)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_ins();
    cmd_valid = '0; cmd_buf_full = '0; fifo_full = '0; credit_nz = '0;
    addr_err = 1'b0; dword_short = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  // drive at falling edge, let one rising edge pass, drop inputs, sample
  task automatic step();
    @(posedge clk);
    #1;
    clear_ins();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    reg_sel = 1'b1;
    #1;
    chk("R11 err after reset", rd_data, 32'h0);
    chk("R11 irq after reset", {31'h0, irq}, 32'h0);

    // R1, R2 status layout and idle
    reg_sel = 1'b0; chan_bufs_empty = 8'hA5; chan_no_pend = 8'h3C;
    #1;
    chk("R1 status word A5/3C", rd_data, 32'hA53C_0000);
    chk("R2 idle A5/3C", {24'h0, chan_idle}, 32'h24);
    chan_bufs_empty = 8'hFF; chan_no_pend = 8'h81;
    #1;
    chk("R1 status word FF/81", rd_data, 32'hFF81_0000);
    chk("R2 idle FF/81", {24'h0, chan_idle}, 32'h81);

    // R3..R8, R10 table walk with the error word selected
    @(negedge clk);
    reg_sel = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      cmd_valid    = VEC[v][98:91];
      cmd_buf_full = VEC[v][90:83];
      fifo_full    = VEC[v][82:75];
      credit_nz    = VEC[v][74:67];
      addr_err     = VEC[v][66];
      dword_short  = VEC[v][65];
      wr_en        = VEC[v][64];
      wr_data      = VEC[v][63:32];
      step();
      chk($sformatf("R3-set/R5/R6/R7/R8 vector %0d", v), rd_data, VEC[v][31:0]);
      chk($sformatf("R10 irq vector %0d", v), {31'h0, irq}, {31'h0, VEC[v][31:0] != 32'h0});
    end

    // R12 all events at once: only defined bits appear
    cmd_valid = '1; cmd_buf_full = '1; fifo_full = '1; credit_nz = '1;
    addr_err = 1'b1; dword_short = 1'b1;
    step();
    chk("R12 all events", rd_data, 32'hC001_FEFF);

    // R7 holds across idle cycles
    repeat (5) @(negedge clk);
    chk("R7 sticky after idle", rd_data, 32'hC001_FEFF);

    // R9 write to status address changes nothing
    reg_sel = 1'b0; wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    step();
    chk("R9 status unchanged", rd_data, 32'hFF81_0000);
    reg_sel = 1'b1;
    #1;
    chk("R9 error word unchanged", rd_data, 32'hC001_FEFF);

    // R4 alone after clearing
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    step();
    chk("R7 full clear", rd_data, 32'h0);
    dword_short = 1'b1;
    step();
    chk("R4 short only", rd_data, 32'h4000_0000);

    // R11 reset with flags set
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 err after mid reset", rd_data, 32'h0);
    chk("R11 irq after mid reset", {31'h0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule